// File: doc/BRIEF.md
# Selectable Input Chatter Filter

This block removes contact bounce from two four-bit port groups before software samples them: a group of input-only pins and a group of bidirectional pins. Each bit is passed through a two-flop synchronizer. A per-bit stability counter then watches the synchronized level. The filtered bit takes a new level only after that level has been present for a chosen number of base-clock enable pulses. Any shorter excursion is discarded.

A single select bit picks the filter span for both groups: 64 enable pulses (short) or 256 enable pulses (long). With a 32.768 kHz base clock these spans are about 1.95 ms and 7.8 ms. The bidirectional group filters only while its direction flag says input. While that group drives its pins, its filtered value is frozen and its counters are held clear.

Top module: `chatter_filter`

## Requirements
- R1: While `rst_n` is low, each filtered output loads the synchronized level of its raw input and every counter clears. After reset is released with the inputs unchanged, `in_filt` equals `in_raw` and `io_filt` equals `io_raw`.
- R2: With `long_sel` = 0, a bit that differs from its filtered value changes its filtered value on the 64th enable pulse that it has held the new level. The filtered value is unchanged after 63 such pulses.
- R3: With `long_sel` = 1, the change occurs on the 256th enable pulse and not after 255.
- R4: When the synchronized level returns to the filtered value, that bit's count restarts from zero. A pulse shorter than the selected span never reaches the output, and a later change needs the full span again.
- R5: Only clock cycles with `base_tick` = 1 advance a count. Any number of cycles without it leaves the filtered outputs unchanged.
- R6: The same `long_sel` value sets the span for the bidirectional group, which needs 256 or 64 pulses exactly as the input-only group does.
- R7: While `io_is_output` = 1, `io_filt` holds its value whatever `io_raw` does, and its counters stay at zero. After a return to input mode, a differing level needs a full span counted from that return.
- R8: Each bit is counted separately. A change on one bit neither advances nor restarts the count of any other bit, in either group.
- R9: If `long_sel` drops from 1 to 0 while a bit's count already equals or exceeds 63, that bit's filtered value changes on the next enable pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_tick | input | 1 | One-cycle enable at the base-clock rate; each pulse is one count |
| long_sel | input | 1 | 1 selects the 256-pulse span, 0 the 64-pulse span, for both groups |
| in_raw | input | 4 | Raw input-only port bits |
| io_raw | input | 4 | Raw bidirectional port bits as seen at the pins |
| io_is_output | input | 1 | 1 while the bidirectional group drives its pins (filtering suspended) |
| in_filt | output | 4 | Filtered input-only bits |
| io_filt | output | 4 | Filtered bidirectional bits |

## Verification
The assertions assume that reset is held low from the first clock edge. They also assume that `base_tick` and the direction flag are clean synchronous signals, so a filtered bit can change only on an edge that carries an enable pulse. The bench drives every input on the falling clock edge. It gives each raw change three clock cycles to pass the synchronizer before it issues any enable pulse. It also issues pulses one at a time with idle cycles between them, so the count of pulses the block sees is exactly the count the bench intends.

// File: rtl/chatter_pkg.sv
// Shared types and helpers for the chatter filter.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package chatter_pkg;

    // Filter span choice, encoded as the select pin value.
    typedef enum logic {
        SPAN_SHORT = 1'b0,
        SPAN_LONG  = 1'b1
    } span_e;

    // Bits needed to hold a count up to and including n.
    function automatic int ctr_bits(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/chatter_sync.sv
// Two-stage synchronizer for a bus of asynchronous pin levels.
// Assumes: bits are independent; no reset, the stages flush within two clocks.
module chatter_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Shift the raw levels through two flops.
    always_ff @(posedge clk) begin
        stage1 <= d_async;
        stage2 <= stage1;
    end

    assign q_sync = stage2;

endmodule

// File: rtl/chatter_bit.sv
// Stability filter for a single synchronized bit.
// The output takes the new level after it has held for `span` enable pulses.
// Assumes: span is between 1 and SPAN_MAX; enable is a one-cycle pulse.
module chatter_bit #(
    parameter int SPAN_MAX = 256,
    parameter int CW       = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          active,
    input  logic [CW-1:0] span,
    input  logic          lvl_sync,
    output logic          lvl_filt
);

    logic [CW-1:0] run_cnt;
    logic [CW:0]   run_next;
    logic          differs;

    // Next count and mismatch flag.
    always_comb begin
        run_next = {1'b0, run_cnt} + {{CW{1'b0}}, 1'b1};
        differs  = (lvl_sync != lvl_filt);
    end

    // Count enable pulses while the level differs; flip at the span.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_filt <= lvl_sync;
            run_cnt  <= '0;
        end else if (!active || !differs) begin
            run_cnt  <= '0;
        end else if (tick_en) begin
            if (run_next >= {1'b0, span}) begin
                lvl_filt <= lvl_sync;
                run_cnt  <= '0;
            end else begin
                run_cnt  <= run_next[CW-1:0];
            end
        end
    end

    // R5: the output only moves on an edge that carried an enable pulse.
    a_r5_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (lvl_filt != $past(lvl_filt))) |-> $past(tick_en));

    // R2: a change always adopts the synchronized level of the prior cycle.
    a_r2_change_to_sync: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (lvl_filt != $past(lvl_filt))) |-> (lvl_filt == $past(lvl_sync)));

    // R4: a matching level clears the running count.
    a_r4_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(lvl_sync) == $past(lvl_filt))) |-> (run_cnt == '0));

    // R3: the count never reaches the longest span.
    a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(run_cnt) < SPAN_MAX));

endmodule

// File: rtl/chatter_group.sv
// One port group: a synchronizer plus one stability filter per bit.
// Assumes: `active` low freezes the whole group (output-driving mode).
module chatter_group #(
    parameter int W        = 4,
    parameter int SPAN_MAX = 256,
    parameter int CW       = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          active,
    input  logic [CW-1:0] span,
    input  logic [W-1:0]  raw_i,
    output logic [W-1:0]  filt_o
);

    logic [W-1:0] synced;

    chatter_sync #(.W(W)) u_sync (
        .clk     (clk),
        .d_async (raw_i),
        .q_sync  (synced)
    );

    // One independent filter per bit.
    for (genvar b = 0; b < W; b++) begin : g_bit
        chatter_bit #(.SPAN_MAX(SPAN_MAX), .CW(CW)) u_bit (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_en  (tick_en),
            .active   (active),
            .span     (span),
            .lvl_sync (synced[b]),
            .lvl_filt (filt_o[b])
        );
    end

    // R7: a group that is not filtering keeps its output.
    a_r7_hold_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(active)) |-> $stable(filt_o));

endmodule

// File: rtl/chatter_filter.sv
// Top: chatter filtering for an input-only group and a bidirectional group.
// One select bit sets the span for both groups; the bidirectional group
// filters only in input mode.
// Assumes: base_tick is a one-cycle pulse at the base-clock rate.
module chatter_filter
    import chatter_pkg::*;
#(
    parameter int W         = 4,
    parameter int SHORT_LEN = 64,
    parameter int LONG_LEN  = 256
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         base_tick,
    input  logic         long_sel,
    input  logic [W-1:0] in_raw,
    input  logic [W-1:0] io_raw,
    input  logic         io_is_output,
    output logic [W-1:0] in_filt,
    output logic [W-1:0] io_filt
);

    localparam int            CW      = ctr_bits(LONG_LEN);
    localparam logic [CW-1:0] SHORT_V = CW'(SHORT_LEN);
    localparam logic [CW-1:0] LONG_V  = CW'(LONG_LEN);

    span_e         mode;
    logic [CW-1:0] span;

    // Decode the shared span select.
    always_comb begin
        mode = span_e'(long_sel);
        span = (mode == SPAN_LONG) ? LONG_V : SHORT_V;
    end

    chatter_group #(.W(W), .SPAN_MAX(LONG_LEN), .CW(CW)) u_in_grp (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (base_tick),
        .active  (1'b1),
        .span    (span),
        .raw_i   (in_raw),
        .filt_o  (in_filt)
    );

    chatter_group #(.W(W), .SPAN_MAX(LONG_LEN), .CW(CW)) u_io_grp (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (base_tick),
        .active  (!io_is_output),
        .span    (span),
        .raw_i   (io_raw),
        .filt_o  (io_filt)
    );

endmodule

// File: tb/sim_chatter_filter.sv
// Directed bench for chatter_filter: one task per scenario.
module sim_chatter_filter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_tick = 1'b0;
    logic       long_sel = 1'b0;
    logic [3:0] in_raw = 4'b1010;
    logic [3:0] io_raw = 4'b0101;
    logic       io_is_output = 1'b0;
    logic [3:0] in_filt;
    logic [3:0] io_filt;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    chatter_filter u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .base_tick    (base_tick),
        .long_sel     (long_sel),
        .in_raw       (in_raw),
        .io_raw       (io_raw),
        .io_is_output (io_is_output),
        .in_filt      (in_filt),
        .io_filt      (io_filt)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Let a raw change pass the synchronizer.
    task automatic settle();
        idle(3);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk) base_tick = 1'b1;
            @(negedge clk) base_tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(5);
        rst_n = 1'b1;
        idle(1);
        chk("R1 in_filt", in_filt, 4'b1010);
        chk("R1 io_filt", io_filt, 4'b0101);
    endtask

    task automatic t_short();
        long_sel = 1'b0;
        in_raw = 4'b1011;
        settle();
        ticks(63);
        chk("R2 63 pulses", in_filt, 4'b1010);
        ticks(1);
        chk("R2 64 pulses", in_filt, 4'b1011);
    endtask

    task automatic t_long();
        long_sel = 1'b1;
        in_raw = 4'b1010;
        settle();
        ticks(255);
        chk("R3 255 pulses", in_filt, 4'b1011);
        ticks(1);
        chk("R3 256 pulses", in_filt, 4'b1010);
    endtask

    task automatic t_glitch();
        long_sel = 1'b0;
        in_raw = 4'b1011;
        settle();
        ticks(63);
        in_raw = 4'b1010;
        settle();
        ticks(1);
        chk("R4 short pulse dropped", in_filt, 4'b1010);
        in_raw = 4'b1011;
        settle();
        ticks(63);
        chk("R4 count restarted", in_filt, 4'b1010);
        ticks(1);
        chk("R4 full span after restart", in_filt, 4'b1011);
    endtask

    task automatic t_no_tick();
        in_raw = 4'b0011;
        settle();
        idle(500);
        chk("R5 no pulses no change", in_filt, 4'b1011);
        ticks(64);
        chk("R5 pulses then change", in_filt, 4'b0011);
    endtask

    task automatic t_io_span();
        io_is_output = 1'b0;
        long_sel = 1'b1;
        io_raw = 4'b0111;
        settle();
        ticks(255);
        chk("R6 io long 255", io_filt, 4'b0101);
        ticks(1);
        chk("R6 io long 256", io_filt, 4'b0111);
        long_sel = 1'b0;
        io_raw = 4'b0110;
        settle();
        ticks(63);
        chk("R6 io short 63", io_filt, 4'b0111);
        ticks(1);
        chk("R6 io short 64", io_filt, 4'b0110);
    endtask

    task automatic t_io_output();
        io_is_output = 1'b1;
        io_raw = 4'b1001;
        settle();
        ticks(300);
        chk("R7 held in output mode", io_filt, 4'b0110);
        chk("R7 input group untouched", in_filt, 4'b0011);
        io_is_output = 1'b0;
        ticks(63);
        chk("R7 span restarts on return", io_filt, 4'b0110);
        ticks(1);
        chk("R7 change after full span", io_filt, 4'b1001);
    endtask

    task automatic t_independent();
        long_sel = 1'b0;
        in_raw = 4'b0111;
        settle();
        ticks(32);
        in_raw = 4'b0101;
        settle();
        ticks(32);
        chk("R8 bit2 flips, bit1 pending", in_filt, 4'b0111);
        ticks(32);
        chk("R8 bit1 flips later", in_filt, 4'b0101);
        chk("R8 io group untouched", io_filt, 4'b1001);
    endtask

    task automatic t_sel_switch();
        long_sel = 1'b1;
        in_raw = 4'b0100;
        settle();
        ticks(100);
        chk("R9 long span not reached", in_filt, 4'b0101);
        @(negedge clk) long_sel = 1'b0;
        ticks(1);
        chk("R9 switch to short flips", in_filt, 4'b0100);
    endtask

    initial begin
        t_reset();
        t_short();
        t_long();
        t_glitch();
        t_no_tick();
        t_io_span();
        t_io_output();
        t_independent();
        t_sel_switch();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule